// File: doc/BRIEF.md
# Bus-Locked Instruction Micro-Sequencer

This block is the timing heart of a small 64-bit RISC-style core. The core clock runs at twice the rate of a 16-bit external bus, so one bus cycle lasts two core clocks. Every 32-bit instruction therefore needs two bus cycles to fetch. The sequencer steps through a four-clock frame. In the first clock it reads the first source register and in the second it reads the second source register, so one register-file port is enough for both operands. The third clock is the execute step and the fourth is the write-back step.

Fetch and execute form a two-stage pipeline under this one sequencer. While one instruction walks through its frame, the two halves of the next instruction arrive over the bus. The low half comes first and the high half second. The assembled word is latched at the end of the frame and executes in the following frame. For a load or a store, the sequencer holds in the execute step and hands the bus to the load/store unit until that unit reports done. An illegal encoding does not execute. Instead the sequencer raises a trap, drops the instruction it has partly fetched and restarts fetch at a vector supplied on an input.

Top module: `bus_useq`

## Requirements
- R1: While `rst_ni` is low, `phase_o` is 0, `fetch_req_o` is 1, `bus_addr_o` equals `RESET_PC` and every strobe is 0. The first frame after reset holds no valid instruction, so it raises no register, execute, write-back or trap strobe.
- R2: `phase_o` steps 0 (first read), 1 (second read), 2 (execute), 3 (write-back) and then back to 0. A non-memory legal instruction that follows a legal instruction gives an execute strobe exactly 4 clocks after the previous execute strobe.
- R3: Phases 0–1 form the low-half bus cycle at address `pc`, and phases 2–3 form the high-half bus cycle at `pc+2`. `bus_rdata_i` is sampled in phase 1 and in phase 3. The word `{high, low}` executes in the next frame, and `pc` then advances by 4.
- R4: `rf_addr_o` carries ir[19:15] with `rs1_stb_o` in phase 0, ir[24:20] with `rs2_stb_o` in phase 1, and ir[11:7] with `wb_stb_o` in phase 3.
- R5: `wb_stb_o` stays low for stores and for any instruction whose destination field ir[11:7] is 0.
- R6: A load (opcode 0000011) or a store (opcode 0100011) raises `lsu_req_o` in phase 2 and holds phase 2 until `lsu_done_i` is seen high. `fetch_req_o` is low while `lsu_req_o` is high. The execute strobe comes on the clock after done, so the frame grows by the number of request clocks.
- R7: Only these opcodes (ir[6:0]) are legal: 0010011, 0110011, 0000011, 0100011, 0110111, 0010111, 0011011, 0111011. Opcodes 0110011 and 0111011 also need ir[31:25] to be 0000000, 0100000 or 0000001. A load with ir[14:12]=111 is illegal, and so is a store with ir[14]=1. An illegal word raises `trap_o` for one clock in phase 2, in place of the execute strobe, with no `lsu_req_o` and no write-back.
- R8: After a trap, fetch restarts at `trap_vec_i` with its low two bits cleared and the partly fetched word is discarded. The next frame is empty. The instruction at the vector gives its execute strobe 7 clocks after the trap, plus any memory stall.
- R9: Fetch overlaps execution. An execute strobe follows the previous execute strobe by 4 clocks plus that instruction's stall, with no fetch-only gap between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock (twice the bus rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_vec_i | input | AW | Fetch restart address on a trap |
| bus_rdata_i | input | BUS_W | Half-word returned by the bus |
| fetch_req_o | output | 1 | Fetch cycle active on the bus |
| bus_addr_o | output | AW | Byte address of the half-word being fetched |
| lsu_done_i | input | 1 | Load/store unit has finished its access |
| lsu_req_o | output | 1 | Stall: the bus is granted to the load/store unit |
| phase_o | output | 2 | Frame phase: 0 read1, 1 read2, 2 execute, 3 write-back |
| ir_o | output | INSN_W | Instruction in execution |
| rf_addr_o | output | 5 | Register-file port address |
| rs1_stb_o | output | 1 | First operand read strobe |
| rs2_stb_o | output | 1 | Second operand read strobe |
| ex_stb_o | output | 1 | Execute strobe |
| wb_stb_o | output | 1 | Register write-back strobe |
| trap_o | output | 1 | Illegal-instruction trap pulse |

## Verification
A program in bench memory is run through the block. It mixes register-immediate and register-register words and a subtract that targets register 0, which shows whether write-back is gated by the destination field. It also has a load and a store with different done latencies, which shows whether the stall length follows the load/store unit. An upper-immediate word checks that operand fields are still read for a format that ignores them. Two kinds of illegal word are included: an unknown opcode and a bad function field. These separate the opcode check from the function check. The code at the vector ends in a second trap, which confirms that the vector can be entered again. Each register address, write-back target and spacing between execute strobes is compared in order against values the bench predicts from the fetched words.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    PH_RD1 = 2'd0,
    PH_RD2 = 2'd1,
    PH_EXE = 2'd2,
    PH_WRB = 2'd3
  } phase_e;

  localparam int RF_AW = 5;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_REGW  = 7'b0111011;

  localparam int NUM_OPS = 8;
  localparam logic [6:0] LEGAL_OPS [NUM_OPS] = '{
    7'b0010011, 7'b0110011, 7'b0000011, 7'b0100011,
    7'b0110111, 7'b0010111, 7'b0011011, 7'b0111011
  };

  localparam int NUM_F7 = 3;
  localparam logic [6:0] LEGAL_F7 [NUM_F7] = '{7'h00, 7'h20, 7'h01};

endpackage

// File: rtl/bus_useq_decode.sv
module bus_useq_decode
  import useq_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] ir_i,
  output logic              illegal_o,
  output logic              is_mem_o,
  output logic              writes_rd_o,
  output logic [RF_AW-1:0]  rs1_o,
  output logic [RF_AW-1:0]  rs2_o,
  output logic [RF_AW-1:0]  rd_o
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [NUM_OPS-1:0] op_hit;
  logic [NUM_F7-1:0]  f7_hit;
  logic op_ok, f7_ok, f3_ok, is_regop;

  assign opc   = ir_i[6:0];
  assign f3    = ir_i[14:12];
  assign f7    = ir_i[31:25];
  assign rd_o  = ir_i[11:7];
  assign rs1_o = ir_i[19:15];
  assign rs2_o = ir_i[24:20];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign op_hit[g] = (opc == LEGAL_OPS[g]);
  end

  for (genvar g = 0; g < NUM_F7; g++) begin : g_f7
    assign f7_hit[g] = (f7 == LEGAL_F7[g]);
  end

  always_comb begin
    op_ok    = |op_hit;
    f7_ok    = |f7_hit;
    is_regop = (opc == OPC_REG) || (opc == OPC_REGW);
    is_mem_o = (opc == OPC_LOAD) || (opc == OPC_STORE);
    f3_ok    = 1'b1;
    if (opc == OPC_LOAD  && f3 == 3'b111) f3_ok = 1'b0;
    if (opc == OPC_STORE && f3[2])        f3_ok = 1'b0;
    illegal_o   = !op_ok || (is_regop && !f7_ok) || !f3_ok;
    writes_rd_o = (opc != OPC_STORE);
  end

endmodule

// File: rtl/bus_useq_phase.sv
module bus_useq_phase
  import useq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ir_vld_i,
  input  logic   is_mem_i,
  input  logic   illegal_i,
  input  logic   lsu_done_i,
  output phase_e phase_o,
  output logic   lsu_req_o,
  output logic   ex_clk_o,
  output logic   trap_o
);

  phase_e phase_q, phase_d;
  logic   served_q;
  logic   in_exe, mem_wait;

  always_comb begin
    in_exe    = (phase_q == PH_EXE);
    trap_o    = in_exe && ir_vld_i && illegal_i;
    mem_wait  = in_exe && ir_vld_i && !illegal_i && is_mem_i && !served_q;
    lsu_req_o = mem_wait;
    // final execute clock: also carries the high-half fetch
    ex_clk_o  = in_exe && !mem_wait && !trap_o;
    unique case (phase_q)
      PH_RD1:  phase_d = PH_RD2;
      PH_RD2:  phase_d = PH_EXE;
      PH_EXE:  phase_d = trap_o ? PH_RD1 : (mem_wait ? PH_EXE : PH_WRB);
      default: phase_d = PH_RD1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_RD1;
      served_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (mem_wait && lsu_done_i) served_q <= 1'b1;
      else if (!mem_wait)         served_q <= 1'b0;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/bus_useq_fetch.sv
module bus_useq_fetch
  import useq_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          BUS_W    = 16,
  parameter int          INSN_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic              ex_clk_i,
  input  logic              trap_i,
  input  logic [AW-1:0]     trap_vec_i,
  input  logic [BUS_W-1:0]  bus_rdata_i,
  output logic              fetch_req_o,
  output logic [AW-1:0]     bus_addr_o,
  output logic [INSN_W-1:0] ir_o,
  output logic              ir_vld_o
);

  localparam int            HALF_BYTES = BUS_W / 8;
  localparam int            INSN_BYTES = INSN_W / 8;
  localparam logic [AW-1:0] ALIGN_MASK = AW'(INSN_BYTES - 1);

  logic [AW-1:0]     pc_q;
  logic [BUS_W-1:0]  lo_q;
  logic [INSN_W-1:0] ir_q;
  logic              vld_q;
  logic              hi_half;

  always_comb begin
    hi_half = (phase_i == PH_EXE) || (phase_i == PH_WRB);
    unique case (phase_i)
      PH_RD1, PH_RD2, PH_WRB: fetch_req_o = 1'b1;
      default:                fetch_req_o = ex_clk_i;
    endcase
    bus_addr_o = pc_q + (hi_half ? AW'(HALF_BYTES) : AW'(0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= AW'(RESET_PC);
      lo_q  <= '0;
      ir_q  <= '0;
      vld_q <= 1'b0;
    end else if (trap_i) begin
      pc_q  <= trap_vec_i & ~ALIGN_MASK;
      vld_q <= 1'b0;
    end else if (phase_i == PH_RD2) begin
      lo_q <= bus_rdata_i;
    end else if (phase_i == PH_WRB) begin
      ir_q  <= {bus_rdata_i, lo_q};
      vld_q <= 1'b1;
      pc_q  <= pc_q + AW'(INSN_BYTES);
    end
  end

  assign ir_o     = ir_q;
  assign ir_vld_o = vld_q;

endmodule

// File: rtl/bus_useq.sv
module bus_useq
  import useq_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          BUS_W    = 16,
  parameter int          INSN_W   = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     trap_vec_i,
  input  logic [BUS_W-1:0]  bus_rdata_i,
  output logic              fetch_req_o,
  output logic [AW-1:0]     bus_addr_o,
  input  logic              lsu_done_i,
  output logic              lsu_req_o,
  output logic [1:0]        phase_o,
  output logic [INSN_W-1:0] ir_o,
  output logic [RF_AW-1:0]  rf_addr_o,
  output logic              rs1_stb_o,
  output logic              rs2_stb_o,
  output logic              ex_stb_o,
  output logic              wb_stb_o,
  output logic              trap_o
);

  phase_e           phase;
  logic             ir_vld, illegal, is_mem, writes_rd, ex_clk, trap;
  logic [RF_AW-1:0] rs1, rs2, rd;

  bus_useq_decode #(.INSN_W(INSN_W)) u_dec (
    .ir_i        (ir_o),
    .illegal_o   (illegal),
    .is_mem_o    (is_mem),
    .writes_rd_o (writes_rd),
    .rs1_o       (rs1),
    .rs2_o       (rs2),
    .rd_o        (rd)
  );

  bus_useq_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ir_vld_i   (ir_vld),
    .is_mem_i   (is_mem),
    .illegal_i  (illegal),
    .lsu_done_i (lsu_done_i),
    .phase_o    (phase),
    .lsu_req_o  (lsu_req_o),
    .ex_clk_o   (ex_clk),
    .trap_o     (trap)
  );

  bus_useq_fetch #(
    .AW(AW), .BUS_W(BUS_W), .INSN_W(INSN_W), .RESET_PC(RESET_PC)
  ) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .ex_clk_i    (ex_clk),
    .trap_i      (trap),
    .trap_vec_i  (trap_vec_i),
    .bus_rdata_i (bus_rdata_i),
    .fetch_req_o (fetch_req_o),
    .bus_addr_o  (bus_addr_o),
    .ir_o        (ir_o),
    .ir_vld_o    (ir_vld)
  );

  // single register-file port, steered by phase
  always_comb begin
    unique case (phase)
      PH_RD1:  rf_addr_o = rs1;
      PH_RD2:  rf_addr_o = rs2;
      PH_WRB:  rf_addr_o = rd;
      default: rf_addr_o = '0;
    endcase
    rs1_stb_o = ir_vld && (phase == PH_RD1);
    rs2_stb_o = ir_vld && (phase == PH_RD2);
    ex_stb_o  = ir_vld && ex_clk;
    wb_stb_o  = ir_vld && (phase == PH_WRB) && writes_rd && (rd != '0);
  end

  assign trap_o  = trap;
  assign phase_o = phase;

endmodule

// File: rtl/bus_useq_chk.sv
module bus_useq_chk #(
  parameter int AW     = 32,
  parameter int INSN_W = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] trap_vec_i,
  input logic          fetch_req_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          lsu_done_i,
  input logic          lsu_req_o,
  input logic [1:0]    phase_o,
  input logic [4:0]    rf_addr_o,
  input logic          rs1_stb_o,
  input logic          rs2_stb_o,
  input logic          ex_stb_o,
  input logic          wb_stb_o,
  input logic          trap_o
);

  localparam int ALIGN = $clog2(INSN_W / 8);

  a_r2_rd1_to_rd2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd0 |=> phase_o == 2'd1);
  a_r2_rd2_to_exe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd1 |=> phase_o == 2'd2);
  a_r2_wrb_to_rd1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd3 |=> phase_o == 2'd0);
  a_r2_ex_then_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_stb_o |=> phase_o == 2'd3);
  a_r4_strobe_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs1_stb_o |-> phase_o == 2'd0) and (rs2_stb_o |-> phase_o == 2'd1)
    and (wb_stb_o |-> phase_o == 2'd3));
  a_r3_half_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> bus_addr_o[1] == phase_o[1]);
  a_r5_no_x0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> rf_addr_o != 5'd0);
  a_r6_hold_exe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsu_req_o && !lsu_done_i |=> phase_o == 2'd2 && lsu_req_o);
  a_r6_bus_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsu_req_o |-> !fetch_req_o);
  a_r7_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ex_stb_o, trap_o, lsu_req_o}));
  a_r8_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> fetch_req_o && phase_o == 2'd0
      && bus_addr_o[AW-1:ALIGN] == $past(trap_vec_i[AW-1:ALIGN]));

endmodule

bind bus_useq bus_useq_chk #(.AW(AW), .INSN_W(INSN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trap_vec_i  (trap_vec_i),
  .fetch_req_o (fetch_req_o),
  .bus_addr_o  (bus_addr_o),
  .lsu_done_i  (lsu_done_i),
  .lsu_req_o   (lsu_req_o),
  .phase_o     (phase_o),
  .rf_addr_o   (rf_addr_o),
  .rs1_stb_o   (rs1_stb_o),
  .rs2_stb_o   (rs2_stb_o),
  .ex_stb_o    (ex_stb_o),
  .wb_stb_o    (wb_stb_o),
  .trap_o      (trap_o)
);

// File: tb/bus_useq_bench.sv
module bus_useq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [31:0] TRAP_VEC = 32'h80;

  localparam int K_RS1 = 1, K_RS2 = 2, K_EX = 3, K_TRAP = 4, K_WB = 5;

  typedef struct {
    int    kind;
    int    val;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lsu_done = 1'b0;
  logic [15:0] rdata;
  logic fetch_req, lsu_req, rs1_stb, rs2_stb, ex_stb, wb_stb, trap;
  logic [AW-1:0] addr;
  logic [1:0] phase;
  logic [31:0] ir;
  logic [4:0] rf_addr;

  logic [31:0] prog [64];
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0, total = 0, popped = 0;
  int cyc = 0, last_ex = 0, lcnt = 0;
  bit sb_done = 1'b0, first_ex = 1'b1, prev_trap = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rdata = addr[1] ? prog[addr[7:2]][31:16] : prog[addr[7:2]][15:0];

  bus_useq u_bus_useq (
    .clk_i(clk), .rst_ni(rst_ni), .trap_vec_i(TRAP_VEC), .bus_rdata_i(rdata),
    .fetch_req_o(fetch_req), .bus_addr_o(addr), .lsu_done_i(lsu_done),
    .lsu_req_o(lsu_req), .phase_o(phase), .ir_o(ir), .rf_addr_o(rf_addr),
    .rs1_stb_o(rs1_stb), .rs2_stb_o(rs2_stb), .ex_stb_o(ex_stb),
    .wb_stb_o(wb_stb), .trap_o(trap)
  );

  function automatic logic [31:0] r_t(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1,
                                     logic [2:0] f3, logic [4:0] d, logic [6:0] op);
    return {f7, s2, s1, f3, d, op};
  endfunction

  function automatic logic [31:0] i_t(logic [11:0] imm, logic [4:0] s1,
                                     logic [2:0] f3, logic [4:0] d, logic [6:0] op);
    return {imm, s1, f3, d, op};
  endfunction

  // legality from R7
  function automatic bit legal(logic [31:0] w);
    logic [6:0] op = w[6:0];
    logic [6:0] f7 = w[31:25];
    case (op)
      7'b0010011, 7'b0110111, 7'b0010111, 7'b0011011: return 1'b1;
      7'b0000011: return w[14:12] != 3'b111;
      7'b0100011: return !w[14];
      7'b0110011, 7'b0111011: return f7 == 7'h00 || f7 == 7'h20 || f7 == 7'h01;
      default: return 1'b0;
    endcase
  endfunction

  task automatic push(int kind, int val, string tag);
    item_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    sb_q.push_back(it);
    total++;
  endtask

  // driver: expected events for one executed word
  task automatic drive_insn(logic [31:0] w);
    int base, stall, gap;
    bit mem;
    push(K_RS1, int'(w[19:15]), "R3/R4");
    push(K_RS2, int'(w[24:20]), "R3/R4");
    base = prev_trap ? 7 : 4;
    if (!legal(w)) begin
      push(K_TRAP, first_ex ? 0 : base, "R7");
      prev_trap = 1'b1;
    end else begin
      mem   = (w[6:0] == 7'b0000011) || (w[6:0] == 7'b0100011);
      stall = mem ? int'(w[8:7]) + 1 : 0;
      gap   = first_ex ? 0 : base + stall;
      push(K_EX, gap, prev_trap ? "R8" : (mem ? "R6" : "R2/R9"));
      // R5: no write-back for stores or destination 0
      if (w[6:0] != 7'b0100011 && w[11:7] != 5'd0) push(K_WB, int'(w[11:7]), "R4");
      prev_trap = 1'b0;
    end
    first_ex = 1'b0;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor plus load/store responder (latency = ir[8:7]+1)
  always @(negedge clk) begin
    int kind, val;
    item_t it;
    if (!rst_ni) begin
      lcnt = 0;
      lsu_done = 1'b0;
    end else begin
      cyc++;
      if (lsu_req) begin
        lcnt++;
        lsu_done = (lcnt == int'(ir[8:7]) + 1);
        check(!fetch_req, "R6 fetch during stall", int'(fetch_req), 0);
      end else begin
        lcnt = 0;
        lsu_done = 1'b0;
      end
      if (!sb_done) begin
        kind = 0; val = 0;
        if ($countones({rs1_stb, rs2_stb, ex_stb, trap, wb_stb}) > 1)
          check(1'b0, "R2 strobe overlap", $countones({rs1_stb, rs2_stb, ex_stb, trap, wb_stb}), 1);
        if (rs1_stb)      begin kind = K_RS1; val = int'(rf_addr); end
        else if (rs2_stb) begin kind = K_RS2; val = int'(rf_addr); end
        else if (ex_stb)  begin kind = K_EX;  val = cyc - last_ex; last_ex = cyc; end
        else if (trap)    begin kind = K_TRAP; val = cyc - last_ex; last_ex = cyc; end
        else if (wb_stb)  begin kind = K_WB;  val = int'(rf_addr); end
        if (kind != 0) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R5 unexpected strobe", kind, 0);
          end else begin
            it = sb_q.pop_front();
            popped++;
            check(kind == it.kind, {it.tag, " event kind"}, kind, it.kind);
            if (kind == it.kind && (it.val != 0 || (kind != K_EX && kind != K_TRAP)))
              check(val == it.val, {it.tag, " event value"}, val, it.val);
            if (popped == total) sb_done = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'h0000_0013;
    prog[0]  = i_t(12'h005, 5'd2, 3'd0, 5'd1, 7'b0010011);
    prog[1]  = r_t(7'h00, 5'd5, 5'd4, 3'd0, 5'd3, 7'b0110011);
    prog[2]  = r_t(7'h20, 5'd7, 5'd6, 3'd0, 5'd0, 7'b0110011);
    prog[3]  = i_t(12'h010, 5'd9, 3'd2, 5'd8, 7'b0000011);
    prog[4]  = {7'h00, 5'd10, 5'd11, 3'd3, 5'b00110, 7'b0100011};
    prog[5]  = {20'h12345, 5'd9, 7'b0110111};
    prog[6]  = 32'h0000_0000;
    prog[32] = r_t(7'h01, 5'd13, 5'd12, 3'd0, 5'd10, 7'b0110011);
    prog[33] = i_t(12'h000, 5'd14, 3'd3, 5'd11, 7'b0000011);
    prog[34] = i_t(12'h001, 5'd15, 3'd0, 5'd12, 7'b0011011);
    prog[35] = r_t(7'h02, 5'd1, 5'd2, 3'd0, 5'd13, 7'b0110011);

    for (int i = 0; i <= 6; i++) drive_insn(prog[i]);
    for (int i = 32; i <= 35; i++) drive_insn(prog[i]);
    drive_insn(prog[32]);
    drive_insn(prog[33]);

    repeat (3) @(negedge clk);
    // R1 reset state
    check(phase == 2'd0, "R1 phase", int'(phase), 0);
    check(fetch_req == 1'b1, "R1 fetch_req", int'(fetch_req), 1);
    check(addr == 32'h0, "R1 bus_addr", int'(addr), 0);
    check({rs1_stb, rs2_stb, ex_stb, wb_stb, trap, lsu_req} == 6'b0, "R1 strobes",
          int'({rs1_stb, rs2_stb, ex_stb, wb_stb, trap, lsu_req}), 0);
    #1 rst_ni = 1'b1;

    for (int i = 0; i < 5000 && !sb_done; i++) @(negedge clk);
    if (!sb_done) check(1'b0, "watchdog", popped, total);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule